// File: doc/BRIEF.md
# Zero-Address Stack Processor Core

This block is a compact processor in which no arithmetic instruction names an operand location. Every instruction is a 32-bit word: the top byte selects the operation and the low 24 bits hold a memory address. Only the two data-moving instructions look at that address. One copies a memory word onto an internal operand stack. The other takes the top entry off the stack and stores it. The three arithmetic instructions consume the two uppermost stack entries and push back a single result.

Code and data share one word-addressed memory behind a plain synchronous port. The port has an address, read data with one cycle of latency, write data and a write strobe. The core sits stopped until `start` is pulsed. It then runs from word 0 through consecutive words until it meets the halt opcode or a fault. While stopped it raises `halted`. The `error` output tells a clean stop from a faulted one.

The memory port is a fixed-latency RAM interface and not a stream. It has no valid/ready handshake and never back-pressures. The core assumes the read data for an address presented in one cycle is there in the next.

Top module: `stack_core`

## Requirements
- R1: After reset `halted` is 1, `error` is 0 and `mem_we` is 0.
- R2: A `start` pulse while stopped empties the stack, clears `error` and runs from word 0. The program counter moves up by one word after every instruction that does not stop the core. `start` has no effect while running.
- R3: Instruction word layout: bits 31:24 are the opcode and bits 23:0 are the address. Encodings: 0x01 load-to-stack, 0x02 store-from-stack, 0x10 add, 0x11 subtract, 0x12 multiply, 0xFF halt. Arithmetic instructions ignore the address bits.
- R4: Opcode 0x01 reads the memory word at the address and places it on top of the stack.
- R5: Opcode 0x02 writes the top entry to memory at the address and removes it from the stack.
- R6: Add and multiply replace the two top entries with their sum or product, modulo 2^32. The product keeps its low 32 bits.
- R7: Subtract replaces the two top entries with (second entry) minus (top entry), modulo 2^32.
- R8: The stack holds 8 entries. Loading with 8 entries present sets `error` and stops the core. Exactly 8 entries is legal.
- R9: Storing from an empty stack, or any arithmetic with fewer than 2 entries, sets `error` and stops the core without writing memory.
- R10: Any opcode outside the six listed sets `error` and stops the core.
- R11: Opcode 0xFF stops the core with `error` left at 0. No later word is executed.
- R12: Every instruction takes a fetch cycle and an execute cycle. Opcode 0x01 takes one more cycle to capture the read word. `halted` is 0 for exactly the sum of those cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin execution at word 0 when stopped |
| mem_addr | output | 24 | Word address to memory |
| mem_rdata | input | 32 | Read data, valid one cycle after the address |
| mem_wdata | output | 32 | Write data (top of stack) |
| mem_we | output | 1 | Write strobe |
| halted | output | 1 | Core is stopped |
| error | output | 1 | Sticky fault flag, cleared by start |

## Verification
In the execute cycle of a store, the core writes the top entry to memory and shrinks the stack, both in that same cycle. An arithmetic instruction likewise reads two entries and writes one back within one cycle. The bench provokes the store case with a store that is followed at once by two loads from the address just written, then an add. The stored value must come back twice, and the sum must land in a second location. Only a correct write, a correct pop and a correct write-back together give the expected value.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int OPC_W = 8;

  localparam logic [OPC_W-1:0] OP_LOAD  = 8'h01;
  localparam logic [OPC_W-1:0] OP_STORE = 8'h02;
  localparam logic [OPC_W-1:0] OP_ADD   = 8'h10;
  localparam logic [OPC_W-1:0] OP_SUB   = 8'h11;
  localparam logic [OPC_W-1:0] OP_MUL   = 8'h12;
  localparam logic [OPC_W-1:0] OP_STOP  = 8'hFF;

  typedef enum logic [1:0] {
    ST_STOP  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EXEC  = 2'd2,
    ST_LOAD  = 2'd3
  } core_state_t;
endpackage

// File: rtl/stk_alu.sv
module stk_alu
  import stk_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [OPC_W-1:0]  op,
  input  logic [DATA_W-1:0] lhs,   // second entry
  input  logic [DATA_W-1:0] rhs,   // top entry
  output logic [DATA_W-1:0] res
);
  always_comb begin
    case (op)
      OP_ADD:  res = lhs + rhs;
      OP_SUB:  res = lhs - rhs;      // later-pushed value is subtracted
      OP_MUL:  res = lhs * rhs;      // low DATA_W bits kept
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/stk_stack.sv
module stk_stack #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push,
  input  logic              pop,
  input  logic              combine,
  input  logic [DATA_W-1:0] push_data,
  input  logic [DATA_W-1:0] comb_data,
  output logic [DATA_W-1:0] top,
  output logic [DATA_W-1:0] second,
  output logic [CNT_W-1:0]  count
);
  logic [DATA_W-1:0] ent [DEPTH];
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  idx_top, idx_sec, idx_free;

  assign idx_free = IDX_W'(cnt);
  assign idx_top  = IDX_W'(cnt - CNT_W'(1));
  assign idx_sec  = IDX_W'(cnt - CNT_W'(2));
  assign top      = ent[idx_top];
  assign second   = ent[idx_sec];
  assign count    = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (clear)   cnt <= '0;
    else if (push)    cnt <= cnt + CNT_W'(1);
    else if (pop)     cnt <= cnt - CNT_W'(1);
    else if (combine) cnt <= cnt - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!clear && push)              ent[idx_free] <= push_data;
    else if (!clear && combine)      ent[idx_sec]  <= comb_data;
  end

  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH)) else $error("stack depth out of range"); // R8
  AST_PUSH_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> cnt < CNT_W'(DEPTH)) else $error("push onto full stack"); // R8
  AST_POP_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> cnt != '0) else $error("pop from empty stack"); // R9
  AST_COMB_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    combine |-> cnt >= CNT_W'(2)) else $error("combine with too few entries"); // R9
endmodule

// File: rtl/stack_core.sv
module stack_core
  import stk_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int ADDR_W  = 24,
  parameter int STACK_D = 8,
  localparam int CNT_W  = $clog2(STACK_D + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              halted,
  output logic              error
);
  core_state_t       state, st_n;
  logic [ADDR_W-1:0] pc, pc_n;
  logic              err, err_n;
  logic              s_clear, s_push, s_pop, s_comb;
  logic [OPC_W-1:0]  opc;
  logic [ADDR_W-1:0] field;
  logic [DATA_W-1:0] top, second, alu_y;
  logic [CNT_W-1:0]  depth;
  logic              full, has1, has2;

  assign opc   = mem_rdata[DATA_W-1 -: OPC_W];
  assign field = mem_rdata[ADDR_W-1:0];
  assign full  = depth == CNT_W'(STACK_D);
  assign has1  = depth != '0;
  assign has2  = depth >= CNT_W'(2);

  stk_stack #(.DATA_W(DATA_W), .DEPTH(STACK_D)) i_stack (
    .clk(clk), .rst_n(rst_n), .clear(s_clear), .push(s_push), .pop(s_pop),
    .combine(s_comb), .push_data(mem_rdata), .comb_data(alu_y),
    .top(top), .second(second), .count(depth)
  );

  stk_alu #(.DATA_W(DATA_W)) i_alu (
    .op(opc), .lhs(second), .rhs(top), .res(alu_y)
  );

  always_comb begin
    st_n = state; pc_n = pc; err_n = err;
    s_clear = 1'b0; s_push = 1'b0; s_pop = 1'b0; s_comb = 1'b0;
    mem_we = 1'b0; mem_addr = pc;
    case (state)
      ST_STOP: if (start) begin
        st_n = ST_FETCH; pc_n = '0; err_n = 1'b0; s_clear = 1'b1;
      end
      ST_FETCH: st_n = ST_EXEC;
      ST_EXEC: begin
        mem_addr = field;
        case (opc)
          OP_LOAD:
            if (full) begin st_n = ST_STOP; err_n = 1'b1; end
            else st_n = ST_LOAD;
          OP_STORE:
            if (!has1) begin st_n = ST_STOP; err_n = 1'b1; end
            else begin
              mem_we = 1'b1; s_pop = 1'b1;
              pc_n = pc + ADDR_W'(1); st_n = ST_FETCH;
            end
          OP_ADD, OP_SUB, OP_MUL:
            if (!has2) begin st_n = ST_STOP; err_n = 1'b1; end
            else begin
              s_comb = 1'b1; pc_n = pc + ADDR_W'(1); st_n = ST_FETCH;
            end
          OP_STOP: st_n = ST_STOP;
          default: begin st_n = ST_STOP; err_n = 1'b1; end
        endcase
      end
      ST_LOAD: begin
        s_push = 1'b1; pc_n = pc + ADDR_W'(1); st_n = ST_FETCH;
      end
      default: st_n = ST_STOP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_STOP; pc <= '0; err <= 1'b0;
    end else begin
      state <= st_n; pc <= pc_n; err <= err_n;
    end
  end

  assign mem_wdata = top;
  assign halted    = state == ST_STOP;
  assign error     = err;

  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> state == ST_STOP) else $error("error flag while running"); // R9
  AST_WE_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> depth == $past(depth) - CNT_W'(1)) else $error("store did not pop"); // R5
  AST_LOAD_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_LOAD |=> depth == $past(depth) + CNT_W'(1)) else $error("load did not push"); // R4
  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_LOAD) |=> pc == $past(pc) + ADDR_W'(1)) else $error("pc not advanced"); // R2
endmodule

// File: tb/test_stack_core.sv
module test_stack_core;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [23:0] mem_addr;
  logic [31:0] mem_rdata;
  logic [31:0] mem_wdata;
  logic        mem_we;
  logic        halted;
  logic        error;

  logic [31:0] ram [256];
  int nchk = 0;
  int nerr = 0;
  int cyc;

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= ram[mem_addr[7:0]];
  end

  stack_core i_stack_core (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_addr(mem_addr),
    .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .halted(halted), .error(error)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ins(input logic [7:0] op, input logic [23:0] a);
    return {op, a};
  endfunction

  task automatic clr();
    for (int i = 0; i < 256; i++) ram[i] = 32'h0;
  endtask

  task automatic run();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!halted && cyc < 2000) begin
      cyc++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    chk("R1 halted", {31'b0, halted}, 32'd1);
    chk("R1 error", {31'b0, error}, 32'd0);
    chk("R1 we", {31'b0, mem_we}, 32'd0);
  endtask

  task automatic t_expr(input logic [31:0] b, input logic [31:0] c,
                        input logic [31:0] d, input logic [31:0] e);
    logic [31:0] exp;
    clr();
    ram[8'h81] = b; ram[8'h82] = c; ram[8'h83] = d; ram[8'h84] = e;
    ram[0] = ins(8'h01, 24'h81); ram[1] = ins(8'h01, 24'h82);
    ram[2] = ins(8'h10, 24'h000055);  // R3 address field ignored
    ram[3] = ins(8'h01, 24'h83); ram[4] = ins(8'h12, 24'h0);
    ram[5] = ins(8'h01, 24'h84); ram[6] = ins(8'h11, 24'h0);
    ram[7] = ins(8'h02, 24'h80); ram[8] = ins(8'hFF, 24'h0);
    exp = (b + c) * d - e;
    run();
    chk("R6 R7 expression result", ram[8'h80], exp);
    chk("R11 clean stop", {31'b0, error}, 32'd0);
    chk("R12 cycle count", cyc, 32'd22);
    chk("R3 ignored field", ram[8'h55], 32'h0);
  endtask

  task automatic t_sub(input logic [31:0] x, input logic [31:0] y);
    clr();
    ram[8'h81] = x; ram[8'h82] = y;
    ram[0] = ins(8'h01, 24'h81); ram[1] = ins(8'h01, 24'h82);
    ram[2] = ins(8'h11, 24'h0); ram[3] = ins(8'h02, 24'h90);
    ram[4] = ins(8'hFF, 24'h0);
    run();
    chk("R7 second minus top", ram[8'h90], x - y);
  endtask

  task automatic t_mul();
    logic [31:0] a = 32'h12345678;
    logic [31:0] b = 32'h9ABCDEF0;
    logic [63:0] full;
    clr();
    ram[8'h81] = a; ram[8'h82] = b;
    ram[0] = ins(8'h01, 24'h81); ram[1] = ins(8'h01, 24'h82);
    ram[2] = ins(8'h12, 24'h0); ram[3] = ins(8'h02, 24'h90);
    ram[4] = ins(8'hFF, 24'h0);
    full = {32'h0, a} * {32'h0, b};
    run();
    chk("R6 product low bits", ram[8'h90], full[31:0]);
  endtask

  task automatic t_full_ok();
    clr();
    for (int i = 0; i < 8; i++) begin
      ram[8'h81 + i] = 32'h100 + i;
      ram[i] = ins(8'h01, 24'h81 + 24'(i));
    end
    ram[8] = ins(8'h02, 24'h90); ram[9] = ins(8'hFF, 24'h0);
    run();
    chk("R8 eight entries legal", {31'b0, error}, 32'd0);
    chk("R4 last pushed on top", ram[8'h90], 32'h107);
  endtask

  task automatic t_overflow();
    clr();
    ram[8'h81] = 32'h5;
    for (int i = 0; i < 9; i++) ram[i] = ins(8'h01, 24'h81);
    ram[9] = ins(8'hFF, 24'h0);
    run();
    chk("R8 overflow error", {31'b0, error}, 32'd1);
    chk("R8 overflow halted", {31'b0, halted}, 32'd1);
    chk("R12 overflow stop cycle", cyc, 32'd26);
  endtask

  task automatic t_underflow();
    clr();
    ram[0] = ins(8'h02, 24'h90); ram[1] = ins(8'hFF, 24'h0);
    ram[8'h90] = 32'hCAFE0001;
    run();
    chk("R9 store empty error", {31'b0, error}, 32'd1);
    chk("R9 no write on fault", ram[8'h90], 32'hCAFE0001);
    clr();
    ram[8'h81] = 32'h7;
    ram[0] = ins(8'h01, 24'h81); ram[1] = ins(8'h10, 24'h0);
    ram[2] = ins(8'hFF, 24'h0);
    run();
    chk("R9 add one entry error", {31'b0, error}, 32'd1);
    chk("R12 fault cycle count", cyc, 32'd5);
  endtask

  task automatic t_illegal();
    clr();
    ram[0] = ins(8'h33, 24'h0); ram[1] = ins(8'hFF, 24'h0);
    run();
    chk("R10 illegal opcode error", {31'b0, error}, 32'd1);
    chk("R10 stop after fetch and execute", cyc, 32'd2);
  endtask

  task automatic t_halt_restart();
    clr();
    ram[8'h81] = 32'h77;
    ram[0] = ins(8'h01, 24'h81); ram[1] = ins(8'hFF, 24'h0);
    ram[2] = ins(8'h02, 24'h90);
    run();
    chk("R11 later word not executed", ram[8'h90], 32'h0);
    chk("R2 start clears error", {31'b0, error}, 32'd0);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); start = 1'b1;  // R2 start while running has no effect
    @(negedge clk); start = 1'b0;
    repeat (6) @(negedge clk);
    chk("R2 start ignored while running", ram[8'h90], 32'h0);
    chk("R2 halted after rerun", {31'b0, halted}, 32'd1);
  endtask

  task automatic t_store_reload();
    clr();
    ram[8'h81] = 32'h0000_1234;
    ram[0] = ins(8'h01, 24'h81); ram[1] = ins(8'h02, 24'h90);
    ram[2] = ins(8'h01, 24'h90); ram[3] = ins(8'h01, 24'h90);
    ram[4] = ins(8'h10, 24'h0);  ram[5] = ins(8'h02, 24'h91);
    ram[6] = ins(8'hFF, 24'h0);
    run();
    chk("R5 stored value", ram[8'h90], 32'h0000_1234);
    chk("R5 store then reload sum", ram[8'h91], 32'h0000_2468);
    chk("R5 clean", {31'b0, error}, 32'd0);
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nerr++;
    $display("FAIL R12 watchdog: actual running expected stopped");
    finish_up();
  end

  initial begin
    clr();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_expr(32'd3, 32'd4, 32'd5, 32'd6);
    t_expr(32'hFFFF_FFFF, 32'd2, 32'h0001_0000, 32'h0002_0000);
    t_sub(32'd10, 32'd3);
    t_sub(32'd3, 32'd10);
    t_mul();
    t_full_ok();
    t_overflow();
    t_underflow();
    t_illegal();
    t_halt_restart();
    t_store_reload();
    finish_up();
  end
endmodule